// File: doc/BRIEF.md
# I2C Memory Slave Protocol Engine

This block is the bit-level slave side of a two-wire serial bus for a byte-addressed memory array. It watches oversampled SCL and SDA inputs, recognises START, repeated START and STOP, and answers one seven-bit device address. A write-direction transfer loads a 16-bit word address, sent high byte first, and can then carry one data byte. A read-direction transfer returns bytes from a persistent address counter. The SDA output is an open-drain enable: when it is high, the line is pulled low.

Writes are committed through a modelled internal write cycle. This cycle starts on the STOP that ends a byte load and lasts a programmable number of clocks. While it runs, the engine refuses to acknowledge its own address, so a host can poll for completion. A write transfer that stops right after the two address bytes only moves the counter. It does not start a write cycle. The array itself is a small synchronous register file held inside the block.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset `sda_oe_o` is low and the address counter is 0000h, so a current-address read returns location 0, whose content is 00h.
- R2: After each byte is shifted out, the counter holds that byte's address plus one. A later current-address read (device byte AFh with no address phase) returns the next location.
- R3: Only device bytes AEh (write) and AFh (read) are acknowledged. Any other byte, including DEh and DFh, gets no acknowledge. The slave then ignores the bus until the next START.
- R4: A write transfer is made of device byte AEh, the address high byte, the address low byte and one data byte. The slave acknowledges each of them by pulling SDA low on the ninth clock. The data byte is stored at the loaded address when the write cycle ends, and the counter then holds that address plus one.
- R5: A random read is made of AEh, the two address bytes, a repeated START and then AFh. The slave acknowledges AFh and sends the byte at the loaded address, MSB first.
- R6: While the write cycle runs, the slave does not acknowledge AEh or AFh. Once the cycle is over, it does acknowledge them.
- R7: In a read, a master acknowledge (SDA low on the ninth clock) makes the slave send the next location, MSB first. A master non-acknowledge (SDA high) ends the read, and SDA stays released.
- R8: A STOP right after the two address bytes loads the counter and starts no write cycle. Bytes clocked after that STOP and before any START get no acknowledge.
- R9: The counter wraps from FFFFh to 0000h. The array is indexed by the low address bits.
- R10: The write cycle lasts exactly `BUSY_CYCLES` clocks, counted from the clock on which the STOP is detected.
- R11: START and STOP are recognised only as SDA edges while SCL is high. `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The assertions assume that each SCL phase lasts at least four clocks, so that the synchroniser and the output register settle before the next edge. They also assume that the master moves SDA only while SCL is low, except for START and STOP. The bench drives ten clocks per phase and changes its data only right after an SCL fall. It keeps a few clocks between every SDA and SCL edge of a START or STOP. Every read and poll is issued only after the previous write cycle has been polled to completion, so the stimulus never asks for data from a location whose commit is still pending.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_e;
  typedef enum logic [1:0] {RL_DEV, RL_AHI, RL_ALO, RL_DATA} role_e;
endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_sync_q, sda_sync_q;
  logic       scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= 2'b11;
      sda_sync_q <= 2'b11;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[0], scl_i};
      sda_sync_q <= {sda_sync_q[0], sda_i};
      scl_d_q    <= scl_sync_q[1];
      sda_d_q    <= sda_sync_q[1];
    end
  end

  assign scl_o      = scl_sync_q[1];
  assign sda_o      = sda_sync_q[1];
  assign scl_rise_o = scl_o & ~scl_d_q;
  assign scl_fall_o = ~scl_o & scl_d_q;
  // line events only count with SCL steady high
  assign start_o    = scl_o & scl_d_q & sda_d_q & ~sda_o;
  assign stop_o     = scl_o & scl_d_q & ~sda_d_q & sda_o;
endmodule

// File: rtl/i2c_wr_timer.sv
module i2c_wr_timer #(
  parameter int unsigned BUSY_CYCLES = 2400000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (go_i) begin
      cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt_q == '0);
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
      rdata_o <= mem_q[raddr_i];
    end
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h57,
  parameter int unsigned MEM_DEPTH   = 256,
  parameter int unsigned BUSY_CYCLES = 2400000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned IDX_W  = $clog2(MEM_DEPTH);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit, wr_go;
  st_e   st_q;
  role_e role_q, role_nx;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, ahi_q, tx_q, wdat_q, rd_data;
  logic [ADDR_W-1:0] ptr_q, waddr_q;
  logic              rw_q, armed_q, mack_q, oe_q;

  i2c_bus_sampler u_smp (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign wr_go = stop_det && armed_q;

  i2c_wr_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .go_i(wr_go), .busy_o(busy), .done_o(commit)
  );

  i2c_mem_array #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk_i, .rst_ni, .we_i(commit), .waddr_i(waddr_q[IDX_W-1:0]), .wdata_i(wdat_q),
    .raddr_i(ptr_q[IDX_W-1:0]), .rdata_o(rd_data)
  );

  always_comb begin
    unique case (role_q)
      RL_DEV:  role_nx = RL_AHI;
      RL_AHI:  role_nx = RL_ALO;
      default: role_nx = RL_DATA;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; role_q <= RL_DEV; cnt_q <= '0;
      sh_q <= '0; ahi_q <= '0; tx_q <= '0; wdat_q <= '0;
      ptr_q <= '0; waddr_q <= '0;
      rw_q <= 1'b0; armed_q <= 1'b0; mack_q <= 1'b0; oe_q <= 1'b0;
    end else if (start_det) begin
      st_q <= ST_RX; role_q <= RL_DEV; cnt_q <= '0; oe_q <= 1'b0; armed_q <= 1'b0;
    end else if (stop_det) begin
      st_q <= ST_IDLE; oe_q <= 1'b0; armed_q <= 1'b0;
      if (armed_q) ptr_q <= waddr_q + 1'b1;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            unique case (role_q)
              RL_DEV: begin
                if (sh_q[7:1] == DEV_ADDR && !busy) begin
                  rw_q <= sh_q[0]; oe_q <= 1'b1; st_q <= ST_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              RL_AHI: begin ahi_q <= sh_q; oe_q <= 1'b1; st_q <= ST_ACK; end
              RL_ALO: begin ptr_q <= {ahi_q, sh_q}; oe_q <= 1'b1; st_q <= ST_ACK; end
              RL_DATA: begin
                wdat_q <= sh_q; waddr_q <= ptr_q; armed_q <= 1'b1;
                oe_q <= 1'b1; st_q <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (role_q == RL_DEV && rw_q) begin
              tx_q <= rd_data; oe_q <= ~rd_data[7]; ptr_q <= ptr_q + 1'b1; st_q <= ST_TX;
            end else begin
              oe_q <= 1'b0; role_q <= role_nx; st_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_q <= 1'b0; st_q <= ST_MACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0}; oe_q <= ~tx_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s; cnt_q <= 4'd9;
          end else if (scl_fall && cnt_q == 4'd9) begin
            cnt_q <= '0;
            if (mack_q) begin
              tx_q <= rd_data; oe_q <= ~rd_data[7]; ptr_q <= ptr_q + 1'b1; st_q <= ST_TX;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2c_mem_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 2400000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_s,
  input logic        oe,
  input logic        busy,
  input st_e         st,
  input role_e       role,
  input logic [15:0] ptr,
  input logic        stop_det
);
  int unsigned busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_len_q <= 0;
    else if (busy) busy_len_q <= busy_len_q + 1;
    else           busy_len_q <= 0;
  end

  p_oe_quiet_scl_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(oe));

  p_nack_while_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !(st == ST_ACK && role == RL_DEV && oe));

  p_ptr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_TX && $past(st) != ST_TX) |-> ptr == $past(ptr) + 16'd1);

  p_stop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (st == ST_IDLE && !oe));

  p_busy_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> busy_len_q == BUSY_CYCLES);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .oe(oe_q), .busy(busy),
  .st(st_q), .role(role_q), .ptr(ptr_q), .stop_det(stop_det)
);

// File: tb/tb_i2c_mem_target.sv
`timescale 1ns/1ps
module tb_i2c_mem_target;
  localparam int BUSY = 400;
  localparam int PH   = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  wire  oe;
  wire  sda_line = sda_m & ~oe;
  int   tests = 0, fails = 0, cyc = 0, mon_err = 0, stop_cyc = 0;
  logic [7:0]  ref_mem [256];
  logic [15:0] ref_ptr = 16'h0000;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_mem_target #(.MEM_DEPTH(256), .BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(oe)
  );

  // per-clock monitor: the output must hold while SCL is high (R11)
  always @(negedge clk) begin
    if (rst_n && scl && prev_scl && oe !== prev_oe) mon_err++;
    prev_scl <= scl;
    prev_oe  <= oe;
  end

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(PH); scl = 1'b1; wclk(PH); sda_m = 1'b0; wclk(PH); scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(PH); scl = 1'b1; wclk(PH); sda_m = 1'b1; wclk(PH);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(PH); scl = 1'b1; wclk(PH); scl = 1'b0;
    end
    sda_m = 1'b1; wclk(PH); scl = 1'b1; wclk(PH/2);
    ack = (sda_line == 1'b0);
    wclk(PH/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(PH); scl = 1'b1; wclk(PH/2); b[i] = sda_line; wclk(PH/2); scl = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1;
    wclk(PH); scl = 1'b1; wclk(PH); scl = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic read_bytes(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(b == ref_mem[ref_ptr[7:0]], tag, b, ref_mem[ref_ptr[7:0]]);
      ref_ptr = ref_ptr + 16'd1;
    end
  endtask

  task automatic cur_read(input int n, input string tag);
    bit a;
    bus_start(); send_byte(8'hAF, a); chk(a, {tag, " dev ack"}, a, 1);
    read_bytes(n, tag);
    bus_stop();
  endtask

  task automatic rand_read(input logic [15:0] addr, input int n, input string tag);
    bit a;
    bus_start();
    send_byte(8'hAE, a);       chk(a, {tag, " AE ack"}, a, 1);
    send_byte(addr[15:8], a);  chk(a, {tag, " hi ack"}, a, 1);
    send_byte(addr[7:0], a);   chk(a, {tag, " lo ack"}, a, 1);
    bus_start();
    send_byte(8'hAF, a);       chk(a, {tag, " AF ack"}, a, 1);
    ref_ptr = addr;
    read_bytes(n, tag);
    bus_stop();
  endtask

  task automatic mem_write(input logic [15:0] addr, input logic [7:0] d);
    bit a;
    bus_start();
    send_byte(8'hAE, a);      chk(a, "R4 dev ack", a, 1);
    send_byte(addr[15:8], a); chk(a, "R4 hi ack", a, 1);
    send_byte(addr[7:0], a);  chk(a, "R4 lo ack", a, 1);
    send_byte(d, a);          chk(a, "R4 data ack", a, 1);
    bus_stop();
    stop_cyc = cyc;
    ref_mem[addr[7:0]] = d;
    ref_ptr = addr + 16'd1;
  endtask

  task automatic poll_done();
    bit a;
    int n = 0;
    int t_ack = 0;
    do begin
      bus_start(); send_byte(8'hAE, a); t_ack = cyc; bus_stop();
      if (n == 0) chk(!a, "R6 first poll nack", a, 0);
      n++;
    end while (!a && n < 40);
    chk(a, "R6 poll ack after write cycle", a, 1);
    chk((t_ack - stop_cyc) >= BUSY, "R10 write cycle length", t_ack - stop_cyc, BUSY);
  endtask

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    wclk(5); rst_n = 1'b1; wclk(5);
    chk(oe == 1'b0, "R1 reset oe", oe, 0);
    cur_read(1, "R1 read after reset");

    bus_start(); send_byte(8'hDE, a); chk(!a, "R3 DEh nack", a, 0);
    send_byte(8'hAE, a); chk(!a, "R3 ignored until START", a, 0);
    bus_stop();

    mem_write(16'h0010, 8'h5A); poll_done();
    cur_read(1, "R4 counter after write");
    rand_read(16'h0010, 1, "R5 random read");
    cur_read(1, "R2 current read next");

    mem_write(16'h0011, 8'hC3); poll_done();
    mem_write(16'h0012, 8'h77); poll_done();
    rand_read(16'h0010, 3, "R7 sequential read");
    wclk(PH);
    chk(oe == 1'b0, "R7 released after nack", oe, 0);

    bus_start();
    send_byte(8'hAE, a); chk(a, "R8 dev ack", a, 1);
    send_byte(8'h00, a); chk(a, "R8 hi ack", a, 1);
    send_byte(8'h12, a); chk(a, "R8 lo ack", a, 1);
    bus_stop();
    ref_ptr = 16'h0012;
    send_byte(8'hAE, a); chk(!a, "R8 idle until START", a, 0);
    cur_read(1, "R8 set address read");

    mem_write(16'hFFFF, 8'hE1); poll_done();
    mem_write(16'h0000, 8'h3C); poll_done();
    rand_read(16'hFFFF, 2, "R9 wrap");

    bus_start(); send_byte(8'hDF, a); chk(!a, "R3 DFh nack", a, 0); bus_stop();

    chk(mon_err == 0, "R11 oe moved with SCL high", mon_err, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule